// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block decides which interrupt a 16550-style serial port reports. Each cycle it looks at the four interrupt-enable bits, the receive error flags, data-ready, the receive fill level compared with the trigger level, a character-timeout flag and the modem-status change flags. It picks the most urgent active source and registers its identification code, along with a single level interrupt line.

The block holds the enable register itself. It also keeps the "transmit holding empty" pending flag, which the register-access strobes set and clear. An IIR read that reports the transmit-empty code acknowledges it. The surrounding UART keeps the FIFOs, the shifter and the address decode. It passes in one-cycle strobes for register accesses and transmitter events, and level inputs for the status conditions.

Top module: `uart_irq_ident`

## Requirements
- R1: One cycle after the inputs are presented, the low nibble of `iir` holds the code of the highest-priority active source. The order is line status 0x6, character timeout 0xC, received data 0x4, transmit empty 0x2, modem status 0x0. When no source is active the low nibble is 0x1.
- R2: The line-status source is active when enable bit 2 is set and any bit of `lsrErr` is set.
- R3: The received-data source is active when enable bit 0 and `dataReady` are set. When `fifoEn` is 1, `fillCount` must also be at least `trigLevel`.
- R4: The character-timeout source is active when `timeoutPend` is set and enable bit 0 is set.
- R5: The modem-status source is active when enable bit 3 is set and any bit of `msrDelta` is set.
- R6: `iir[7:6]` is 2'b11 one cycle after `fifoEn` is 1, and 2'b00 otherwise. `iir[5:4]` is always 0.
- R7: An `ierWe` strobe loads `ierWdata[3:0]` into the enable register, shown on `ier` the next cycle. The upper four bits are dropped. Bit 0 enables received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R8: An enable write that changes bit 1 sets the pending flag if the new bit 1 and `thrEmpty` are both 1, and clears it otherwise. This evaluation overrides every other event in the same cycle. An enable write that leaves bit 1 unchanged does not touch the flag.
- R9: `txDrained` or `txFifoReset` sets the pending flag, and `thrWrite` clears it. If a set and a clear arrive in the same cycle, the set wins. The transmit-empty source is the pending flag gated by enable bit 1.
- R10: An `iirRead` strobe while the reported code is 0x2 clears the pending flag. A read while any other code is reported leaves the flag unchanged.
- R11: `irq` is a registered level. It is high exactly when the registered code is not 0x1.
- R12: After reset, `ier` is 0, the pending flag is clear, `iir` is 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ierWe | input | 1 | Enable register write strobe |
| ierWdata | input | 8 | Enable register write data |
| iirRead | input | 1 | Identification register read strobe |
| thrWrite | input | 1 | Transmit holding register write strobe |
| txDrained | input | 1 | Transmitter emptied the holding register or FIFO |
| txFifoReset | input | 1 | Transmit FIFO reset strobe |
| thrEmpty | input | 1 | Holding-empty status level |
| fifoEn | input | 1 | FIFO mode enabled |
| lsrErr | input | 4 | Overrun, parity, framing and break flags |
| dataReady | input | 1 | Receive data ready |
| fillCount | input | CNT_W | Receive FIFO fill count |
| trigLevel | input | CNT_W | Receive trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| msrDelta | input | 4 | Modem status change flags |
| ier | output | 4 | Enable register contents |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request level |

## Verification
On every cycle the assertions check several relations. Line status preempts everything when it is enabled and active. Timeout wins whenever line status is idle. The FIFO bits follow `fifoEn`, an enable write loads its low nibble, and an all-zero enable keeps `irq` low. The bench's scenarios are needed for the rest: the pending-flag history, and R10's acknowledge-by-read, which depends on which code was visible. They also cover same-cycle conflicts between enable writes, drains and holding-register writes, and the trigger-level boundary at equality. The bench's reference model replays all of these on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THR     = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irqId_e;

  typedef struct packed {
    logic ierLoad;
    logic pendSet;
    logic pendClr;
  } pendStrobe_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        ierWe,
  input  logic        ierWbit1,
  input  logic        ierQbit1,
  input  logic        thrEmpty,
  input  logic        thrWrite,
  input  logic        txDrained,
  input  logic        txFifoReset,
  input  logic        iirRead,
  input  irqId_e      idCode,
  output pendStrobe_t strb
);
  logic thriChange;
  logic setEvt;
  logic clrEvt;
  logic thriEval;

  always_comb begin
    thriChange = ierWe && (ierWbit1 != ierQbit1);
    thriEval   = ierWbit1 && thrEmpty;
    setEvt     = txDrained || txFifoReset;
    clrEvt     = thrWrite || (iirRead && (idCode == ID_THR));
    strb.ierLoad = ierWe;
    if (thriChange) begin
      strb.pendSet = thriEval;
      strb.pendClr = !thriEval;
    end else begin
      strb.pendSet = setEvt;
      strb.pendClr = clrEvt && !setEvt;
    end
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pendStrobe_t      strb,
  input  logic [3:0]       ierWdata,
  input  logic             fifoEn,
  input  logic [3:0]       lsrErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] fillCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       msrDelta,
  output logic [3:0]       ierQ,
  output irqId_e           idCode,
  output logic [7:0]       iirOut,
  output logic             irqOut
);
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  logic   thrPend;
  logic   fifoBits;
  irqId_e codeNext;
  logic   lineAct, tmoAct, rxAct, thrAct, msAct, levelOk;

  always_comb begin
    levelOk  = !fifoEn || (fillCount >= trigLevel);
    lineAct  = ierQ[EN_LS] && (|lsrErr);
    tmoAct   = ierQ[EN_RX] && timeoutPend;
    rxAct    = ierQ[EN_RX] && dataReady && levelOk;
    thrAct   = ierQ[EN_TX] && thrPend;
    msAct    = ierQ[EN_MS] && (|msrDelta);
    if (lineAct)     codeNext = ID_LINE;
    else if (tmoAct) codeNext = ID_TIMEOUT;
    else if (rxAct)  codeNext = ID_RXDATA;
    else if (thrAct) codeNext = ID_THR;
    else if (msAct)  codeNext = ID_MODEM;
    else             codeNext = ID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ierQ     <= '0;
      thrPend  <= 1'b0;
      idCode   <= ID_NONE;
      irqOut   <= 1'b0;
      fifoBits <= 1'b0;
    end else begin
      if (strb.ierLoad) ierQ <= ierWdata;
      if (strb.pendSet)      thrPend <= 1'b1;
      else if (strb.pendClr) thrPend <= 1'b0;
      idCode   <= codeNext;
      irqOut   <= (codeNext != ID_NONE);
      fifoBits <= fifoEn;
    end
  end

  assign iirOut = {fifoBits, fifoBits, 2'b00, idCode};

  // R2
  line_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ierQ[EN_LS] && (|lsrErr)) |=> (iirOut[3:0] == 4'h6));

  // R4
  tmo_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ierQ[EN_RX] && timeoutPend && !(ierQ[EN_LS] && (|lsrErr))) |=> (iirOut[3:0] == 4'hC));

  // R11
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ierQ == 4'h0) |=> !irqOut);

  // R6
  fifo_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEn |=> (iirOut[7:4] == 4'hC));

  // R6
  fifo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn |=> (iirOut[7:4] == 4'h0));

  // R7
  ier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ierLoad |=> (ierQ == $past(ierWdata)));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ierWe,
  input  logic [7:0]       ierWdata,
  input  logic             iirRead,
  input  logic             thrWrite,
  input  logic             txDrained,
  input  logic             txFifoReset,
  input  logic             thrEmpty,
  input  logic             fifoEn,
  input  logic [3:0]       lsrErr,
  input  logic             dataReady,
  input  logic [CNT_W-1:0] fillCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             timeoutPend,
  input  logic [3:0]       msrDelta,
  output logic [3:0]       ier,
  output logic [7:0]       iir,
  output logic             irq
);
  pendStrobe_t strb;
  irqId_e      idCode;
  logic [3:0]  ierQ;
  logic [7:0]  unusedHigh;

  assign unusedHigh = {ierWdata[7:4], 4'h0};

  uart_irq_ctrl u_ctrl (
    .ierWe       (ierWe),
    .ierWbit1    (ierWdata[1]),
    .ierQbit1    (ierQ[1]),
    .thrEmpty    (thrEmpty),
    .thrWrite    (thrWrite),
    .txDrained   (txDrained),
    .txFifoReset (txFifoReset),
    .iirRead     (iirRead),
    .idCode      (idCode),
    .strb        (strb)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .ierWdata    (ierWdata[3:0]),
    .fifoEn      (fifoEn),
    .lsrErr      (lsrErr),
    .dataReady   (dataReady),
    .fillCount   (fillCount),
    .trigLevel   (trigLevel),
    .timeoutPend (timeoutPend),
    .msrDelta    (msrDelta),
    .ierQ        (ierQ),
    .idCode      (idCode),
    .iirOut      (iir),
    .irqOut      (irq)
  );

  assign ier = ierQ;
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ierWe = 0, iirRead = 0, thrWrite = 0, txDrained = 0, txFifoReset = 0;
  logic thrEmpty = 0, fifoEn = 0, dataReady = 0, timeoutPend = 0;
  logic [7:0] ierWdata = 0;
  logic [3:0] lsrErr = 0, msrDelta = 0;
  logic [CW-1:0] fillCount = 0, trigLevel = 0;
  logic [3:0] ier;
  logic [7:0] iir;
  logic irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int mIer = 0;
  bit mPend = 0;
  int mCode = 1;
  bit mFifo = 0;

  always #5 clk = ~clk;

  uart_irq_ident #(.CNT_W(CW)) i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ierWe(ierWe), .ierWdata(ierWdata),
    .iirRead(iirRead), .thrWrite(thrWrite), .txDrained(txDrained),
    .txFifoReset(txFifoReset), .thrEmpty(thrEmpty), .fifoEn(fifoEn),
    .lsrErr(lsrErr), .dataReady(dataReady), .fillCount(fillCount),
    .trigLevel(trigLevel), .timeoutPend(timeoutPend), .msrDelta(msrDelta),
    .ier(ier), .iir(iir), .irq(irq)
  );

  function automatic int pickCode(int en, bit pend);
    bit rxOk;
    rxOk = !fifoEn || (int'(fillCount) >= int'(trigLevel));
    if ((en & 4) != 0 && lsrErr != 0) return 6;
    if ((en & 1) != 0 && timeoutPend) return 12;
    if ((en & 1) != 0 && dataReady && rxOk) return 4;
    if ((en & 2) != 0 && pend) return 2;
    if ((en & 8) != 0 && msrDelta != 0) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mIer = 0; mPend = 0; mCode = 1; mFifo = 0;
    end else begin
      int oldIer;
      bit p;
      oldIer = mIer;
      mCode = pickCode(oldIer, mPend);
      p = mPend;
      if (thrWrite || (iirRead && iir[3:0] == 4'h2)) p = 0;
      if (txDrained || txFifoReset) p = 1;
      if (ierWe && (ierWdata[1] != oldIer[1])) p = ierWdata[1] && thrEmpty;
      mPend = p;
      if (ierWe) mIer = int'(ierWdata[3:0]);
      mFifo = fifoEn;
    end
  end

  function automatic string tagFor(int c);
    case (c)
      6: return "R2";
      12: return "R4";
      4: return "R3";
      2: return "R9";
      0: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tagFor(mCode), int'(iir[3:0]), mCode);
      check("R11", int'(irq), (mCode != 1) ? 1 : 0);
      check("R6", int'(iir[7:4]), mFifo ? 12 : 0);
      check("R7", int'(ier), mIer);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulseIer(logic [7:0] v);
    ierWe = 1; ierWdata = v; tick(); ierWe = 0;
  endtask

  task automatic pulseRead();
    iirRead = 1; tick(); iirRead = 0;
  endtask

  initial begin
    tick(3);
    // R12 reset values
    check("R12", int'(iir), 8'h01);
    check("R12", int'(irq), 0);
    check("R12", int'(ier), 0);
    rst_n = 1;
    tick(2);

    // R7 upper bits dropped; R8 enabling THRI with THRE set
    thrEmpty = 1;
    pulseIer(8'hF2);
    tick();
    check("R7", int'(ier), 4'h2);
    check("R8", int'(iir[3:0]), 2);

    // R10 read acknowledges transmit-empty
    pulseRead();
    tick();
    check("R10", int'(iir[3:0]), 1);
    check("R11", int'(irq), 0);

    // R9 drain sets, thr write clears, simultaneous set wins
    txDrained = 1; tick(); txDrained = 0; tick();
    check("R9", int'(iir[3:0]), 2);
    thrWrite = 1; tick(); thrWrite = 0; tick();
    check("R9", int'(iir[3:0]), 1);
    thrWrite = 1; txFifoReset = 1; tick(); thrWrite = 0; txFifoReset = 0; tick();
    check("R9", int'(iir[3:0]), 2);

    // R8 write not changing bit1 keeps flag; disable then re-enable with THRE low
    pulseIer(8'h0B); tick();
    check("R8", int'(iir[3:0]), 2);
    thrEmpty = 0;
    pulseIer(8'h09); pulseIer(8'h0B); tick();
    check("R8", int'(iir[3:0]), 1);
    // R8 overrides same-cycle drain
    pulseIer(8'h09);
    ierWe = 1; ierWdata = 8'h0B; txDrained = 1; tick(); ierWe = 0; txDrained = 0; tick();
    check("R8", int'(iir[3:0]), 1);

    // R5 modem, R2 line, R10 read under another code keeps flag
    pulseIer(8'h0F); txDrained = 1; tick(); txDrained = 0;
    msrDelta = 4'h4; lsrErr = 4'h2; tick(2);
    check("R2", int'(iir[3:0]), 6);
    pulseRead(); lsrErr = 0; tick();
    check("R10", int'(iir[3:0]), 2);
    pulseIer(8'h09); tick();
    check("R5", int'(iir[3:0]), 0);
    msrDelta = 0;

    // R3 trigger boundary in FIFO mode, R4 timeout over data
    fifoEn = 1; dataReady = 1; trigLevel = 5'd8; fillCount = 5'd7; tick(2);
    check("R3", int'(iir[3:0]), 1);
    check("R6", int'(iir[7:6]), 3);
    fillCount = 5'd8; tick(2);
    check("R3", int'(iir[3:0]), 4);
    timeoutPend = 1; tick(2);
    check("R4", int'(iir[3:0]), 12);
    pulseIer(8'h08); tick();
    check("R4", int'(iir[3:0]), 1);
    fifoEn = 0; tick(2);
    check("R6", int'(iir[7:6]), 0);
    timeoutPend = 0; dataReady = 0;

    // mixed stimulus compared against the model every clock
    for (int k = 0; k < 600; k++) begin
      bit [31:0] r;
      r = $urandom;
      ierWe = (r[3:0] == 0);
      ierWdata = r[15:8];
      iirRead = r[4] & r[5];
      thrWrite = (r[7:6] == 0);
      txDrained = (r[17:16] == 0);
      txFifoReset = (r[20:18] == 0);
      thrEmpty = r[21];
      fifoEn = r[22];
      lsrErr = (r[25:23] == 0) ? r[29:26] : 4'h0;
      dataReady = r[30];
      timeoutPend = (r[31] & r[0]);
      msrDelta = (r[2:1] == 0) ? r[11:8] : 4'h0;
      fillCount = CW'($urandom_range(0, 16));
      trigLevel = CW'($urandom_range(1, 14));
      tick();
    end
    ierWe = 0; iirRead = 0; thrWrite = 0; txDrained = 0; txFifoReset = 0;
    tick(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule